// File: doc/BRIEF.md
# Triple interval timer

Three independent 16-bit down-counters share one byte-wide register port. Software first writes a control byte to pick a counter, its byte-access order and its operating mode, then loads the count through that counter's data address. Each counter has its own count-enable input, which marks the cycles that count as input clocks, and its own output. A counter can run in one of three modes. In terminal-count mode it raises a flag once and keeps it raised. In rate mode it gives one short low pulse every N input clocks, which suits a seconds tick. In square mode it gives a square wave at the input rate divided by N, which suits a tone source.

A typical use chains the counters outside the block. A rate counter turns a slow reference into a one-per-second enable for a terminal-count counter, and that counter's output becomes an interrupt request. The interrupt handler reloads the count, and the reload clears the request. A latch command takes a snapshot of a running count, so that a two-byte read returns a consistent value.

Top module: `pit_timer`

## Requirements
- R1: Address 3 is the control port and addresses 0, 1 and 2 are the data ports of counters 0, 1 and 2. In a control byte, bits 7:6 select the counter and a select value of 3 is ignored. Bits 5:4 give the access code and bits 3:1 the mode. Bit 0 has no effect, because counting is always binary. Mode values 2 and 6 select rate mode, 3 and 7 select square mode, and every other value selects terminal-count mode. A read at address 3 returns 0.
- R2: Access code 11 transfers the low byte and then the high byte, for both writes and reads. Code 01 transfers only the low byte and writing it clears the high byte. Code 10 transfers only the high byte and writing it clears the low byte.
- R3: Access code 00 is a latch command. It captures the selected counter's count. Reads then return the captured value, while the counter keeps running, until the last byte of that value has been read. After that, reads return the live count again.
- R4: Terminal-count mode: a control byte sets the output low, and writing the final byte of a count also sets it low. The count is loaded on the first enabled clock after that write. The output goes high on the (N+1)th enabled clock and stays high until the counter is reloaded or gets a control byte. Writing only the low byte of a pending two-byte load leaves the output as it is.
- R5: Rate mode: a control byte sets the output high. After loading, the output is low for exactly one enabled clock out of every N, with the first low on the Nth enabled clock after the load. The counter then reloads N by itself. N must be at least 2.
- R6: Square mode: a control byte sets the output high. The output is high for ceil(N/2) enabled clocks and low for floor(N/2) enabled clocks, repeating. After k enabled clocks the output is high when N - ((k-1) mod N) > N/2.
- R7: A loaded value of 0 counts as 65536.
- R8: A counter only advances on cycles where its count-enable input is high. When enable and write are both low, its output does not change.
- R9: A control byte, latch command, data write or read aimed at one counter does not change the waveform of the other counters.
- R10: After reset every output is low, every count reads 0, and every counter uses two-byte access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 to 2 are data ports, 3 is the control port |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, advances the read byte order |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current address |
| cnt_en_i | input | 3 | Per-counter enable: a high cycle counts as one input clock |
| out_o | output | 3 | Per-counter output |

## Verification
The hardest state to reach is the 65536-clock terminal count of a zero load. The bench loads 0 in terminal-count mode, holds enable high and checks the output on both sides of the 65537th enabled clock. The latch check is also hard to reach, because the captured value depends on the exact clock at which the latch byte lands while the counter is running. The bench counts every clock from the enable onward, works out the value frozen at that edge, and then reads it back several cycles later while counting continues.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    KIND_TC   = 2'd0,
    KIND_RATE = 2'd1,
    KIND_SQ   = 2'd2
  } kind_e;

  function automatic kind_e kind_of(input logic [2:0] m);
    if (!m[1]) return KIND_TC;
    return m[0] ? KIND_SQ : KIND_RATE;
  endfunction

endpackage

// File: rtl/pit_port.sv
module pit_port
  import pit_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 2
) (
  input  logic [AW-1:0]          addr_i,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [NCH-1:0][DW-1:0] ch_rdata_i,
  output logic [NCH-1:0]         ctl_we_o,
  output acc_e                   acc_o,
  output logic [2:0]             mode_o,
  output logic [NCH-1:0]         data_we_o,
  output logic [NCH-1:0]         rd_re_o,
  output logic [DW-1:0]          rdata_o
);

  logic ctl_hit;

  assign ctl_hit = wr_i && (addr_i == AW'(NCH));
  assign acc_o   = acc_e'(wdata_i[5:4]);
  assign mode_o  = wdata_i[3:1];

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign ctl_we_o[c]  = ctl_hit && (wdata_i[7:6] == 2'(c));
    assign data_we_o[c] = wr_i && (addr_i == AW'(c));
    assign rd_re_o[c]   = rd_i && (addr_i == AW'(c));
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == AW'(c)) rdata_o = ch_rdata_i[c];
    end
  end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          ctl_we_i,
  input  acc_e          acc_i,
  input  logic [2:0]    mode_i,
  input  logic          data_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_re_i,
  output logic [DW-1:0] rdata_o,
  output logic          out_o,
  output kind_e         kind_o
);

  localparam int unsigned W = 2 * DW;

  acc_e          acc_q;
  kind_e         kind_q;
  logic          wr_hi_q, rd_hi_q, latched_q, load_pend_q, running_q, out_q;
  logic [DW-1:0] lo_stage_q;
  logic [W-1:0]  reload_q, count_q, latch_q, half_q;

  logic [W-1:0]  wr_val, cnt_nx, half_nx, rd_val;
  logic [W:0]    eff_nx, eff_rl;
  logic          wr_done, take_reload, out_nx, advance;

  // assembled load value for the current access code
  always_comb begin
    wr_val  = '0;
    wr_done = 1'b0;
    case (acc_q)
      ACC_LO: begin
        wr_val  = {{DW{1'b0}}, wdata_i};
        wr_done = data_we_i;
      end
      ACC_HI: begin
        wr_val  = {wdata_i, {DW{1'b0}}};
        wr_done = data_we_i;
      end
      default: begin
        wr_val  = {wdata_i, lo_stage_q};
        wr_done = data_we_i && wr_hi_q;
      end
    endcase
  end

  // next count, with 0 standing for 2**W
  assign take_reload = load_pend_q || ((kind_q != KIND_TC) && (count_q == W'(1)));
  assign cnt_nx      = take_reload ? reload_q : count_q - 1'b1;
  assign eff_nx      = {cnt_nx == '0, cnt_nx};
  assign eff_rl      = {reload_q == '0, reload_q};
  assign half_nx     = take_reload ? eff_rl[W:1] : half_q;
  assign advance     = en_i && (running_q || load_pend_q);

  always_comb begin
    case (kind_q)
      KIND_RATE: out_nx = (cnt_nx != W'(1));
      KIND_SQ:   out_nx = (eff_nx > {1'b0, half_nx});
      default:   out_nx = out_q || (!load_pend_q && (count_q == W'(1)));
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= ACC_BOTH;
      kind_q      <= KIND_TC;
      wr_hi_q     <= 1'b0;
      rd_hi_q     <= 1'b0;
      latched_q   <= 1'b0;
      load_pend_q <= 1'b0;
      running_q   <= 1'b0;
      out_q       <= 1'b0;
      lo_stage_q  <= '0;
      reload_q    <= '0;
      count_q     <= '0;
      latch_q     <= '0;
      half_q      <= '0;
    end else begin
      if (advance) begin
        count_q <= cnt_nx;
        half_q  <= half_nx;
        out_q   <= out_nx;
        if (load_pend_q) begin
          load_pend_q <= 1'b0;
          running_q   <= 1'b1;
        end
      end
      if (ctl_we_i) begin
        if (acc_i == ACC_LATCH) begin
          if (!latched_q) begin
            latch_q   <= count_q;
            latched_q <= 1'b1;
          end
        end else begin
          acc_q       <= acc_i;
          kind_q      <= kind_of(mode_i);
          wr_hi_q     <= 1'b0;
          rd_hi_q     <= 1'b0;
          latched_q   <= 1'b0;
          running_q   <= 1'b0;
          load_pend_q <= 1'b0;
          out_q       <= (kind_of(mode_i) != KIND_TC);
        end
      end
      if (data_we_i) begin
        if (acc_q == ACC_BOTH) begin
          wr_hi_q <= !wr_hi_q;
          if (!wr_hi_q) lo_stage_q <= wdata_i;
        end
        if (wr_done) begin
          reload_q <= wr_val;
          if (kind_q == KIND_TC) begin
            out_q       <= 1'b0;
            load_pend_q <= 1'b1;
            running_q   <= 1'b0;
          end else if (!running_q) begin
            load_pend_q <= 1'b1;
          end
        end
      end
      if (rd_re_i) begin
        if ((acc_q == ACC_BOTH) && !rd_hi_q) begin
          rd_hi_q <= 1'b1;
        end else begin
          rd_hi_q   <= 1'b0;
          latched_q <= 1'b0;
        end
      end
    end
  end

  assign rd_val = latched_q ? latch_q : count_q;

  always_comb begin
    case (acc_q)
      ACC_LO:  rdata_o = rd_val[DW-1:0];
      ACC_HI:  rdata_o = rd_val[W-1:DW];
      default: rdata_o = rd_hi_q ? rd_val[W-1:DW] : rd_val[DW-1:0];
    endcase
  end

  assign out_o  = out_q;
  assign kind_o = kind_q;

endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter  int unsigned NCH = 3,
  parameter  int unsigned DW  = 8,
  localparam int unsigned AW  = $clog2(NCH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic [NCH-1:0] cnt_en_i,
  output logic [NCH-1:0] out_o
);

  logic [NCH-1:0]         ctl_we_w, data_we_w, rd_re_w;
  acc_e                   acc_w;
  logic [2:0]             mode_w;
  logic [NCH-1:0][DW-1:0] ch_rdata_w;
  logic [NCH-1:0][1:0]    kind_w;

  pit_port #(.NCH(NCH), .DW(DW), .AW(AW)) u_port (
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .ch_rdata_i (ch_rdata_w),
    .ctl_we_o   (ctl_we_w),
    .acc_o      (acc_w),
    .mode_o     (mode_w),
    .data_we_o  (data_we_w),
    .rd_re_o    (rd_re_w),
    .rdata_o    (rdata_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    kind_e kind_c;
    pit_channel #(.DW(DW)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (cnt_en_i[c]),
      .ctl_we_i  (ctl_we_w[c]),
      .acc_i     (acc_w),
      .mode_i    (mode_w),
      .data_we_i (data_we_w[c]),
      .wdata_i   (wdata_i),
      .rd_re_i   (rd_re_w[c]),
      .rdata_o   (ch_rdata_w[c]),
      .out_o     (out_o[c]),
      .kind_o    (kind_c)
    );
    assign kind_w[c] = kind_c;
  end

endmodule

// File: rtl/pit_chk.sv
module pit_chk
  import pit_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [AW-1:0]       addr_i,
  input logic                wr_i,
  input logic [DW-1:0]       wdata_i,
  input logic [DW-1:0]       rdata_i,
  input logic [NCH-1:0]      en_i,
  input logic [NCH-1:0]      out_i,
  input logic [NCH-1:0][1:0] kind_i
);

  logic ctl_wr;
  assign ctl_wr = wr_i && (addr_i == AW'(NCH));

  AST_CTRL_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(NCH)) |-> (rdata_i == '0)); // R1

  for (genvar c = 0; c < NCH; c++) begin : g_ast
    AST_TC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind_i[c] == KIND_TC) && out_i[c] && !(wr_i && (addr_i == AW'(c))) && !ctl_wr
      |=> out_i[c]); // R4

    AST_TC_CTL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctl_wr && (wdata_i[7:6] == 2'(c)) && (wdata_i[5:4] != 2'b00) && !wdata_i[2]
      |=> !out_i[c]); // R4

    AST_RATE_ONE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind_i[c] == KIND_RATE) && !out_i[c] && en_i[c] && !ctl_wr
      |=> out_i[c]); // R5

    AST_EN_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[c] && !wr_i |=> $stable(out_i[c])); // R8
  end

endmodule

bind pit_timer pit_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rdata_i (rdata_o),
  .en_i    (cnt_en_i),
  .out_i   (out_o),
  .kind_i  (kind_w)
);

// File: tb/sim_pit_timer.sv
module sim_pit_timer;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] en = '0;
  logic [2:0] out;

  int n_chk = 0;
  int n_fail = 0;
  int ticks = 0;
  int t0, tl, tz;
  logic [7:0] v, v2;

  always #(CLK_P/2) clk = ~clk;

  pit_timer u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .addr_i   (addr),
    .wr_i     (wr),
    .rd_i     (rd),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .cnt_en_i (en),
    .out_o    (out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    ticks++;
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    tick();
    rd = 1'b0;
  endtask

  task automatic ctl(input int c, input int acc, input int mode);
    bwr(2'd3, {c[1:0], acc[1:0], mode[2:0], 1'b0});
  endtask

  task automatic load16(input int c, input int n);
    bwr(c[1:0], n[7:0]);
    bwr(c[1:0], n[15:8]);
  endtask

  function automatic int sq_exp(input int n, input int k);
    int nn;
    nn = (n == 0) ? 65536 : n;
    return ((nn - ((k - 1) % nn)) > nn / 2) ? 1 : 0;
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk("R10 outputs low", int'(out), 0);
    brd(2'd0, v);  chk("R10 count low byte", int'(v), 0);
    brd(2'd0, v);  chk("R10 count high byte", int'(v), 0);
    brd(2'd3, v);  chk("R1 control read zero", int'(v), 0);

    // R4 terminal-count sweep on every counter
    for (int c = 0; c < 3; c++) begin
      for (int n = 1; n <= 6; n++) begin
        en[c] = 1'b0;
        ctl(c, 3, 0);
        chk("R4 control sets low", int'(out[c]), 0);
        load16(c, n);
        en[c] = 1'b1;
        for (int k = 1; k <= n + 2; k++) begin
          tick();
          chk("R4 terminal count", int'(out[c]), (k >= n + 1) ? 1 : 0);
        end
        en[c] = 1'b0;
        for (int k = 0; k < 3; k++) begin
          tick();
          chk("R8 hold without enable", int'(out[c]), 1);
        end
        bwr(c[1:0], n[7:0]);
        chk("R4 low byte keeps output", int'(out[c]), 1);
        bwr(c[1:0], 8'h00);
        chk("R4 reload sets low", int'(out[c]), 0);
      end
    end

    // R5 rate sweep on counter 1, mode codes 2 and 6 (R1)
    for (int n = 2; n <= 7; n++) begin
      en[1] = 1'b0;
      ctl(1, 3, (n % 2 == 0) ? 6 : 2);
      chk("R5 control sets high", int'(out[1]), 1);
      load16(1, n);
      en[1] = 1'b1;
      for (int k = 1; k <= 3 * n; k++) begin
        tick();
        chk("R5 rate pulse", int'(out[1]), (k % n != 0) ? 1 : 0);
      end
    end
    en[1] = 1'b0;

    // R6 square sweep on counter 2, mode codes 3 and 7 (R1)
    for (int n = 1; n <= 8; n++) begin
      en[2] = 1'b0;
      ctl(2, 3, (n % 2 == 1) ? 7 : 3);
      chk("R6 control sets high", int'(out[2]), 1);
      load16(2, n);
      en[2] = 1'b1;
      for (int k = 1; k <= 3 * n; k++) begin
        tick();
        chk("R6 square duty", int'(out[2]), sq_exp(n, k));
      end
    end
    en[2] = 1'b0;

    // R2 access codes
    ctl(0, 1, 0);
    bwr(2'd0, 8'h05);
    en[0] = 1'b1; tick(); en[0] = 1'b0;
    brd(2'd0, v);  chk("R2 low-only read", int'(v), 5);
    ctl(0, 2, 0);
    bwr(2'd0, 8'h02);
    en[0] = 1'b1; tick(); en[0] = 1'b0;
    brd(2'd0, v);  chk("R2 high-only read", int'(v), 2);
    ctl(0, 3, 0);
    load16(0, 16'h1234);
    en[0] = 1'b1; tick(); en[0] = 1'b0;
    brd(2'd0, v);  brd(2'd0, v2);
    chk("R2 two-byte read", int'({v2, v}), 16'h1234);
    en[0] = 1'b1; repeat (4) tick(); en[0] = 1'b0;
    brd(2'd0, v);  brd(2'd0, v2);
    chk("R2 live count after 4", int'({v2, v}), 16'h1230);

    // R3 latch while running
    ctl(1, 3, 2);
    load16(1, 1000);
    en[1] = 1'b1;
    t0 = ticks;
    repeat (10) tick();
    tl = ticks;
    bwr(2'd3, 8'h40);
    repeat (5) tick();
    brd(2'd1, v);  brd(2'd1, v2);
    chk("R3 latched value", int'({v2, v}), 1000 - (tl - t0) + 1);
    en[1] = 1'b0;
    tz = ticks;
    brd(2'd1, v);  brd(2'd1, v2);
    chk("R3 live after latch read", int'({v2, v}), 1001 - (tz - t0));

    // R9 isolation: counter 0 square N=4 while others are programmed
    en = '0;
    ctl(0, 3, 3);
    load16(0, 4);
    en[0] = 1'b1;
    t0 = ticks;
    ctl(1, 3, 0);
    chk("R9 ch0 after ch1 control", int'(out[0]), sq_exp(4, ticks - t0));
    load16(1, 1);
    chk("R9 ch0 after ch1 load", int'(out[0]), sq_exp(4, ticks - t0));
    en[1] = 1'b1;
    tick(); tick();
    en[1] = 1'b0;
    chk("R4 ch1 N=1 high", int'(out[1]), 1);
    chk("R9 ch0 during ch1 count", int'(out[0]), sq_exp(4, ticks - t0));
    ctl(2, 3, 2);
    chk("R9 ch0 after ch2 control", int'(out[0]), sq_exp(4, ticks - t0));
    bwr(2'd3, 8'hC0);
    chk("R1 select 3 ignored", int'(out[1]), 1);
    chk("R1 select 3 ignored ch2", int'(out[2]), 1);
    chk("R9 ch0 after select 3", int'(out[0]), sq_exp(4, ticks - t0));
    bwr(2'd3, 8'h80);
    brd(2'd2, v);
    chk("R9 ch0 after ch2 latch/read", int'(out[0]), sq_exp(4, ticks - t0));
    brd(2'd3, v);
    chk("R1 control read zero running", int'(v), 0);
    for (int k = 0; k < 8; k++) begin
      tick();
      chk("R9 ch0 waveform", int'(out[0]), sq_exp(4, ticks - t0));
    end
    en[0] = 1'b0;

    // R7 zero load counts 65536
    ctl(0, 3, 0);
    load16(0, 0);
    en[0] = 1'b1;
    repeat (65535) tick();
    chk("R7 before terminal", int'(out[0]), 0);
    tick();
    chk("R7 at 65536", int'(out[0]), 0);
    tick();
    chk("R7 at 65537", int'(out[0]), 1);
    en[0] = 1'b0;

    ctl(2, 3, 3);
    load16(2, 0);
    en[2] = 1'b1;
    tick();
    chk("R7 square zero load high", int'(out[2]), 1);
    en[2] = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule